// File: doc/BRIEF.md
# Management Serial Slave Decoder

This block is the slave side of a two-wire management bus: a clock line driven by a station manager and a bidirectional data line. Both lines are brought into the system clock domain and the management clock's rising edges become sampling strobes. A frame opens when the last 32 sampled bits form a run of thirty ones, then a zero, then a one. After that opening, a 2-bit operation, a 5-bit device address, a 5-bit register index, two turnaround bits and sixteen data bits follow. Every field passes through one shift register, and each field has its own bit-count target.

A read addressed to this device loads the selected sixteen-bit register when the turnaround ends. The block then drives the value most significant bit first, and each bit changes on the falling management clock edge. A write collects sixteen bits and commits them after the last bit, through a per-register read-only mask. The data pin is a tri-state pair: a data-out signal and an output enable. Integration logic places it on the pad.

Top module: `mgmt_bus_slave`

## Requirements
- R1: After reset the output enable is low. Register 4 holds 0x01E1, register 1 holds 0x7809, and every other register holds 0. The read-only masks are 0xFFFF for register 1, 0x001F for register 4, and 0 for all others.
- R2: A frame starts only when the 32 most recent sampled bits equal 0xFFFFFFFD, with the newest bit in the LSB. A shorter run of ones before the 0,1 pair starts nothing.
- R3: After the start, the fields are operation (2 bits), device address (5), register index (5), turnaround (2) and data (16). Each field is sent MSB first and sampled on the rising management clock edge.
- R4: On a read addressed to this device, the output enable is high for the whole data phase. Data bit 15-k is driven after the falling edge that precedes the k-th data rising edge. The enable drops after the 16th data bit.
- R5: Operation code 1 is a write. It changes only the bits whose mask bit is 0, and only after the 16th data bit. Masked bits keep their value.
- R6: A frame whose device address differs from `phy_addr_i` never raises the output enable and changes no register.
- R7: Operation codes 0 and 3 raise no output enable and change no register. Operation code 2 is a read.
- R8: A register index of 8 or more reads as 0 and ignores writes. It is not aliased onto a lower index.
- R9: After the data phase the block returns to idle. A new frame needs a new start pattern, and a frame sent without one gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mclk_i | input | 1 | Management clock from the station manager |
| mdat_i | input | 1 | Management data line as seen at the pad |
| phy_addr_i | input | 5 | Strapped device address |
| mdat_o | output | 1 | Data driven toward the pad |
| mdat_oe_o | output | 1 | Pad output enable |

## Verification
The assertions assume that `phy_addr_i` is static for the length of a frame. They also assume that each management clock level lasts at least four system clocks, so that every edge is seen once after synchronisation. The bench keeps the strap fixed and holds each management clock half-period for four system clocks. It changes data only while the management clock is low and samples read data just before raising the clock. Random reads and writes use addresses that mostly match the strap, and register indices that include out-of-range values.

// File: rtl/mgs_pkg.sv
package mgs_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_OPC, ST_DEV, ST_IDX, ST_TA, ST_DAT} fsm_e;
  localparam logic [1:0]  OP_WR      = 2'b01;
  localparam logic [1:0]  OP_RD      = 2'b10;
  localparam logic [31:0] START_WORD = 32'hFFFF_FFFD;
  localparam int OPC_W = 2;
  localparam int DEV_W = 5;
  localparam int IDX_W = 5;
  localparam int TA_W  = 2;
  localparam int DAT_W = 16;
  localparam int CNT_W = $clog2(DAT_W + 1);
endpackage

// File: rtl/mgs_sync.sv
module mgs_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mclk_i,
  input  logic mdat_i,
  output logic rise_o,
  output logic fall_o,
  output logic dat_o
);
  logic [1:0] clk_ff, dat_ff;
  logic       clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_ff <= '0;
      dat_ff <= '0;
      clk_q  <= 1'b0;
    end else begin
      clk_ff <= {clk_ff[0], mclk_i};
      dat_ff <= {dat_ff[0], mdat_i};
      clk_q  <= clk_ff[1];
    end
  end

  assign rise_o = clk_ff[1] & ~clk_q;
  assign fall_o = ~clk_ff[1] & clk_q;
  assign dat_o  = dat_ff[1];
endmodule

// File: rtl/mgs_regfile.sv
module mgs_regfile #(
  parameter int NUM_REGS = 8,
  parameter logic [NUM_REGS*16-1:0] RST_VALS = '0,
  parameter logic [NUM_REGS*16-1:0] RO_MASKS = '0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [4:0]  idx_i,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] rd_data_o
);
  localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [15:0] q [NUM_REGS];
  logic        in_range;

  assign in_range  = int'(idx_i) < NUM_REGS;
  assign rd_data_o = in_range ? q[idx_i[AW-1:0]] : 16'h0000;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [15:0] RO = RO_MASKS[i*16 +: 16];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        q[i] <= RST_VALS[i*16 +: 16];
      else if (wr_en_i && int'(idx_i) == i)
        q[i] <= (q[i] & RO) | (wr_data_i & ~RO);
    end

    AST_RO_BITS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((q[i] & RO) == ($past(q[i]) & RO))); // R5
  end
endmodule

// File: rtl/mgs_frame.sv
module mgs_frame
  import mgs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        dat_i,
  input  logic [4:0]  dev_addr_i,
  input  logic [15:0] rd_data_i,
  output logic [4:0]  idx_o,
  output logic        wr_en_o,
  output logic [15:0] wr_data_o,
  output logic        dout_o,
  output logic        oe_o
);
  fsm_e             state;
  logic [31:0]      sh, sh_nx;
  logic [CNT_W-1:0] cnt, cnt_nx, target;
  logic [1:0]       opc_q;
  logic [4:0]       dev_q, idx_q;
  logic             hit, start_hit, field_done;
  fsm_e             state_nx;

  always_comb begin
    sh_nx  = {sh[30:0], dat_i};
    cnt_nx = cnt + 1'b1;
    unique case (state)
      ST_OPC:  begin target = CNT_W'(OPC_W); state_nx = ST_DEV;  end
      ST_DEV:  begin target = CNT_W'(DEV_W); state_nx = ST_IDX;  end
      ST_IDX:  begin target = CNT_W'(IDX_W); state_nx = ST_TA;   end
      ST_TA:   begin target = CNT_W'(TA_W);  state_nx = ST_DAT;  end
      ST_DAT:  begin target = CNT_W'(DAT_W); state_nx = ST_IDLE; end
      default: begin target = '0;            state_nx = ST_OPC;  end
    endcase
  end

  assign hit        = (dev_q == dev_addr_i);
  assign start_hit  = rise_i && (state == ST_IDLE) && (sh_nx == START_WORD);
  assign field_done = rise_i && (state != ST_IDLE) && (cnt_nx == target);

  assign wr_en_o   = field_done && (state == ST_DAT) && (opc_q == OP_WR) && hit;
  assign wr_data_o = sh_nx[15:0];
  assign idx_o     = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= ST_IDLE;
      sh     <= '0;
      cnt    <= '0;
      opc_q  <= '0;
      dev_q  <= '0;
      idx_q  <= '0;
      dout_o <= 1'b0;
      oe_o   <= 1'b0;
    end else if (rise_i) begin
      if (start_hit || field_done) begin
        state <= state_nx;
        sh    <= '0;
        cnt   <= '0;
        unique case (state)
          ST_OPC: opc_q <= sh_nx[1:0];
          ST_DEV: dev_q <= sh_nx[4:0];
          ST_IDX: idx_q <= sh_nx[4:0];
          ST_TA: if (opc_q == OP_RD && hit) begin
            sh   <= {16'h0000, rd_data_i};
            oe_o <= 1'b1;
          end
          ST_DAT: oe_o <= 1'b0;
          default: ;
        endcase
      end else begin
        sh  <= sh_nx;
        cnt <= (state == ST_IDLE) ? '0 : cnt_nx;
      end
    end else if (fall_i && state == ST_DAT && oe_o) begin
      dout_o <= sh[15];
    end
  end

  AST_OE_IN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> state == ST_DAT); // R4
  AST_OE_READ_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> (opc_q == OP_RD && dev_q == dev_addr_i)); // R6
  AST_OE_DROP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> state == ST_IDLE); // R9
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < CNT_W'(DAT_W)); // R3
  AST_DEV_THEN_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_DEV |=> (state == ST_DEV || state == ST_IDX)); // R3
  AST_WR_LAST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (state == ST_DAT && cnt == CNT_W'(DAT_W - 1))); // R5
endmodule

// File: rtl/mgmt_bus_slave.sv
module mgmt_bus_slave #(
  parameter int NUM_REGS = 8,
  parameter logic [NUM_REGS*16-1:0] RST_VALS =
    {16'h0000, 16'h0000, 16'h0000, 16'h01E1, 16'h0000, 16'h0000, 16'h7809, 16'h0000},
  parameter logic [NUM_REGS*16-1:0] RO_MASKS =
    {16'h0000, 16'h0000, 16'h0000, 16'h001F, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000}
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mclk_i,
  input  logic       mdat_i,
  input  logic [4:0] phy_addr_i,
  output logic       mdat_o,
  output logic       mdat_oe_o
);
  logic        rise, fall, dat;
  logic [4:0]  idx;
  logic        wr_en;
  logic [15:0] wr_data, rd_data;

  mgs_sync u_sync (
    .clk_i, .rst_ni, .mclk_i, .mdat_i,
    .rise_o(rise), .fall_o(fall), .dat_o(dat)
  );

  mgs_frame u_frame (
    .clk_i, .rst_ni,
    .rise_i(rise), .fall_i(fall), .dat_i(dat),
    .dev_addr_i(phy_addr_i), .rd_data_i(rd_data),
    .idx_o(idx), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .dout_o(mdat_o), .oe_o(mdat_oe_o)
  );

  mgs_regfile #(
    .NUM_REGS(NUM_REGS), .RST_VALS(RST_VALS), .RO_MASKS(RO_MASKS)
  ) u_regs (
    .clk_i, .rst_ni,
    .idx_i(idx), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data)
  );
endmodule

// File: tb/mgmt_bus_slave_tb_top.sv
module mgmt_bus_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam logic [4:0] STRAP = 5'd3;

  logic clk = 1'b0, rst_n = 1'b0, mclk = 1'b0, mdat = 1'b1;
  logic mdat_o, mdat_oe_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] mdl [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  mgmt_bus_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mclk_i(mclk), .mdat_i(mdat),
    .phy_addr_i(STRAP), .mdat_o(mdat_o), .mdat_oe_o(mdat_oe_o)
  );

  function automatic logic [15:0] rst_val(int i);
    return (i == 4) ? 16'h01E1 : (i == 1) ? 16'h7809 : 16'h0000;
  endfunction
  function automatic logic [15:0] ro_mask(int i);
    return (i == 4) ? 16'h001F : (i == 1) ? 16'hFFFF : 16'h0000;
  endfunction
  function automatic logic [15:0] exp_rd(int i);
    return (i < 8) ? mdl[i] : 16'h0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    mclk = 1'b0; mdat = b; tick(HALF);
    mclk = 1'b1; tick(HALF);
  endtask

  task automatic preamble();
    repeat (32) send_bit(1'b1);
  endtask

  // start pair, op, device, index, turnaround, then 16 data bits with capture
  task automatic frame(input bit pre, input logic [1:0] op, input logic [4:0] dev,
                       input logic [4:0] idx, input logic [15:0] wd,
                       output logic [15:0] rd, output bit oe_all, output bit oe_any);
    if (pre) preamble();
    send_bit(1'b0); send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 4; i >= 0; i--) send_bit(dev[i]);
    for (int i = 4; i >= 0; i--) send_bit(idx[i]);
    send_bit(1'b1); send_bit(op == 2'b10 ? 1'b1 : 1'b0);
    oe_all = 1'b1; oe_any = 1'b0; rd = '0;
    for (int i = 15; i >= 0; i--) begin
      mclk = 1'b0; mdat = (op == 2'b10) ? 1'b1 : wd[i]; tick(HALF);
      rd[i] = mdat_o;
      oe_all &= mdat_oe_o;
      oe_any |= mdat_oe_o;
      mclk = 1'b1; tick(HALF);
    end
    tick(HALF);
  endtask

  task automatic do_write(input logic [4:0] dev, input logic [4:0] idx, input logic [15:0] wd);
    logic [15:0] rd; bit a, b;
    frame(1'b1, 2'b01, dev, idx, wd, rd, a, b);
    chk(!b, "R5 oe stays low on write", 32'(b), 0);
    if (dev == STRAP && idx < 8) mdl[idx] = (mdl[idx] & ro_mask(idx)) | (wd & ~ro_mask(idx));
  endtask

  task automatic do_read(input logic [4:0] dev, input logic [4:0] idx, input string tag);
    logic [15:0] rd; bit a, b;
    frame(1'b1, 2'b10, dev, idx, 16'h0, rd, a, b);
    if (dev == STRAP) begin
      chk(a, {tag, " R4 oe high through data"}, 32'(a), 1);
      chk(rd == exp_rd(idx), {tag, " R3 read data"}, 32'(rd), 32'(exp_rd(idx)));
    end else begin
      chk(!b, {tag, " R6 oe low for foreign address"}, 32'(b), 0);
    end
    chk(!mdat_oe_o, {tag, " R9 oe released after frame"}, 32'(mdat_oe_o), 0);
  endtask

  initial begin
    logic [15:0] rd; bit a, b;
    for (int i = 0; i < 8; i++) mdl[i] = rst_val(i);
    void'($urandom(32'd1234));
    tick(3); rst_n = 1'b1; tick(2);
    chk(!mdat_oe_o, "R1 oe low after reset", 32'(mdat_oe_o), 0);
    for (int i = 0; i < 8; i++) do_read(STRAP, 5'(i), "R1 reset value");

    do_write(STRAP, 5'd0, 16'hA5C3);
    do_read(STRAP, 5'd0, "R5 plain write");
    do_write(STRAP, 5'd1, 16'h0000);
    do_read(STRAP, 5'd1, "R5 fully masked");
    do_write(STRAP, 5'd4, 16'hFFFF);
    do_read(STRAP, 5'd4, "R5 partial mask");
    chk(mdl[4] == 16'hFFE1, "R5 model partial mask", 32'(mdl[4]), 32'hFFE1);

    do_write(5'd7, 5'd2, 16'h1234);
    do_read(STRAP, 5'd2, "R6 foreign write ignored");
    do_read(5'd9, 5'd0, "R6 foreign read");

    frame(1'b1, 2'b00, STRAP, 5'd3, 16'hBEEF, rd, a, b);
    chk(!b, "R7 op 0 no drive", 32'(b), 0);
    frame(1'b1, 2'b11, STRAP, 5'd3, 16'hBEEF, rd, a, b);
    chk(!b, "R7 op 3 no drive", 32'(b), 0);
    do_read(STRAP, 5'd3, "R7 no write from op 0/3");

    do_read(STRAP, 5'd9, "R8 out of range");
    do_write(STRAP, 5'd12, 16'h5555);
    do_read(STRAP, 5'd4, "R8 no alias on write");

    repeat (20) send_bit(1'b1);
    frame(1'b0, 2'b10, STRAP, 5'd4, 16'h0, rd, a, b);
    chk(!b, "R2 short preamble no start", 32'(b), 0);
    do_read(STRAP, 5'd4, "R2 full preamble recovers");

    frame(1'b0, 2'b10, STRAP, 5'd0, 16'h0, rd, a, b);
    chk(!b, "R9 frame without start pattern", 32'(b), 0);

    for (int n = 0; n < 40; n++) begin
      logic [4:0] dev, idx;
      dev = ($urandom % 5 == 0) ? 5'($urandom) : STRAP;
      idx = 5'($urandom % 10);
      if ($urandom % 2) do_write(dev, idx, 16'($urandom));
      else do_read(dev, idx, "R3 random read");
    end
    for (int i = 0; i < 8; i++) do_read(STRAP, 5'(i), "R5 final sweep");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule